// File: doc/BRIEF.md
# Slave Serial Configuration Loader

This block loads a configuration image into a programmable logic device through its serial configuration pins. When a start command arrives, it pulls the device's program line low for a long reset interval. Data and clock stay high during that interval. It then releases the program line and waits a short settling time. After that it takes image bytes one at a time over a valid/ready handshake and sends each one out on a single data line, most significant bit first. It also generates the configuration clock on which the device samples every bit.

Once the number of bytes given at start has been sent, the block samples the device's completion input once per cycle, up to a bounded number of polls. If the device reports completion in time, the block raises a one-cycle success pulse. If not, it raises a timeout flag, which stays set until the next start. Busy covers the whole sequence. In idle, the program, clock and data lines are all high. The reset interval, the settling wait and the clock half-period are cycle-count parameters. The contents of the image are not inspected.

Top module: `ssc_loader`

## Requirements
- R1: One cycle after `start_i` is sampled in idle, `prog_n_o` goes low and stays low for exactly RST_HOLD cycles. During that time `cclk_o` and `din_o` are high.
- R2: After `prog_n_o` returns high, the block waits exactly REL_WAIT cycles before asserting `byte_ready_o` for the first byte. If a byte is already offered, the first low clock phase starts REL_WAIT+1 cycles after the release.
- R3: Each bit is driven on `din_o` while `cclk_o` is low. The low phase lasts HALF_PER cycles and the high phase HALF_PER cycles. `din_o` never changes in the cycle in which `cclk_o` rises.
- R4: Each accepted byte yields exactly eight rising edges of `cclk_o`. The bit on `din_o` at the n-th rising edge is byte bit 7-n, so bit 7 goes first. Bytes go out in acceptance order, and exactly `count_i` bytes are taken.
- R5: `byte_ready_o` is high only while waiting for a byte. For every byte after the first, that is only after the eighth rising edge of the previous byte. One byte is taken per cycle in which `byte_ready_o` and `byte_valid_i` are both high.
- R6: With `count_i` equal to 0, no clock pulse is produced. The block goes from the settling wait straight to polling, so busy lasts RST_HOLD+REL_WAIT+1 cycles when `done_i` is already high.
- R7: After the last bit, `done_i` is sampled once per cycle. The first sample found high ends the run: `ok_o` pulses for one cycle and `busy_o` falls in that same cycle.
- R8: If POLL_LIMIT consecutive samples of `done_i` are all low, `timeout_o` is set and `busy_o` falls. The high phase of the last bit plus the polling window take HALF_PER+POLL_LIMIT cycles. `timeout_o` stays high until the next start, and it is cleared one cycle after that start.
- R9: After reset and whenever not busy, `prog_n_o`, `cclk_o` and `din_o` are high, and `busy_o`, `byte_ready_o` and `ok_o` are low.
- R10: `start_i` is ignored while busy. The program line is not pulsed again, and the byte stream under way is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, sampled in idle |
| count_i | input | CNT_W | Number of image bytes, latched at start |
| byte_i | input | 8 | Image byte offered |
| byte_valid_i | input | 1 | Image byte on `byte_i` is valid |
| byte_ready_o | output | 1 | Block takes the offered byte this cycle |
| done_i | input | 1 | Device completion input |
| prog_n_o | output | 1 | Device program line, active low |
| cclk_o | output | 1 | Configuration clock to the device |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | One-cycle pulse on completion seen |
| timeout_o | output | 1 | Completion not seen within the poll limit, held until next start |

## Verification
Bytes are captured on every rising clock edge and rebuilt. The byte patterns cover all-ones, all-zeros, alternating bits and sequences whose lowest or highest bit toggles from byte to byte. Together these tell a correct most-significant-first order from a reversed, rotated or stuck bit.

The vector runs differ in the number of bytes (zero, one and several) and in how long the completion input stays low (immediately high, late, never). This separates the success path from the timeout path and checks the exact cycle counts of each phase. One run repeats the start command in the middle of a transfer to show that it has no effect. A timeout run followed by a new start shows that the flag is held and then cleared.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG,
    S_WREL,
    S_FETCH,
    S_SHIFT,
    S_POLL
  } ssc_state_e;

  // Largest of three cycle counts, used to size the shared timer.
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // A phase lasting n cycles loads the down-counter with n-1.
  function automatic int unsigned span_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/ssc_timer.sv
module ssc_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load_i)       cnt <= val_i;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired_o = (cnt == '0);

endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       step_i,
  output logic       bit_o,
  output logic       low_o,
  output logic       last_hi_o
);

  logic [7:0] sh;
  logic [2:0] idx;
  logic       low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= '0;
      low <= 1'b0;
    end else if (load_i) begin
      sh  <= byte_i;
      idx <= '0;
      low <= 1'b1;
    end else if (step_i) begin
      if (low) begin
        low <= 1'b0;
      end else begin
        low <= 1'b1;
        sh  <= {sh[6:0], 1'b0};
        idx <= idx + 3'd1;
      end
    end
  end

  assign bit_o     = sh[7];
  assign low_o     = low;
  assign last_hi_o = !low && (idx == 3'd7);

endmodule

// File: rtl/ssc_loader.sv
module ssc_loader
  import ssc_pkg::*;
#(
  parameter int unsigned RST_HOLD   = 2400,
  parameter int unsigned REL_WAIT   = 16,
  parameter int unsigned HALF_PER   = 4,
  parameter int unsigned POLL_LIMIT = 1000,
  parameter int unsigned CNT_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic             done_i,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             din_o,
  output logic             busy_o,
  output logic             ok_o,
  output logic             timeout_o
);

  localparam int unsigned TW = $clog2(max3(RST_HOLD, REL_WAIT, HALF_PER) + 1);
  localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
  localparam logic [TW-1:0] T_HOLD = TW'(span_load(RST_HOLD));
  localparam logic [TW-1:0] T_REL  = TW'(span_load(REL_WAIT));
  localparam logic [TW-1:0] T_HALF = TW'(span_load(HALF_PER));
  localparam logic [PW-1:0] P_LAST = PW'(span_load(POLL_LIMIT));

  ssc_state_e       state, nxt;
  logic [CNT_W-1:0] rem;
  logic [PW-1:0]    polls;
  logic             t_load, t_exp;
  logic [TW-1:0]    t_val;
  logic             sh_load, sh_step, sh_bit, sh_low, sh_last;
  logic             ok_set, to_set;

  // Named events for the checker
  logic accept_w, rise_w, start_w;

  ssc_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val), .expired_o(t_exp)
  );

  ssc_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(sh_load), .byte_i(byte_i), .step_i(sh_step),
    .bit_o(sh_bit), .low_o(sh_low), .last_hi_o(sh_last)
  );

  always_comb begin
    nxt          = state;
    t_load       = 1'b0;
    t_val        = '0;
    sh_load      = 1'b0;
    sh_step      = 1'b0;
    byte_ready_o = 1'b0;
    ok_set       = 1'b0;
    to_set       = 1'b0;
    case (state)
      S_IDLE: if (start_i) begin
        nxt = S_PROG; t_load = 1'b1; t_val = T_HOLD;
      end
      S_PROG: if (t_exp) begin
        nxt = S_WREL; t_load = 1'b1; t_val = T_REL;
      end
      S_WREL: if (t_exp) nxt = (rem == '0) ? S_POLL : S_FETCH;
      S_FETCH: begin
        byte_ready_o = 1'b1;
        if (byte_valid_i) begin
          nxt = S_SHIFT; sh_load = 1'b1; t_load = 1'b1; t_val = T_HALF;
        end
      end
      S_SHIFT: if (t_exp) begin
        if (sh_last) nxt = (rem == '0) ? S_POLL : S_FETCH;
        else begin
          sh_step = 1'b1; t_load = 1'b1; t_val = T_HALF;
        end
      end
      S_POLL: begin
        if (done_i) begin
          ok_set = 1'b1; nxt = S_IDLE;
        end else if (polls == P_LAST) begin
          to_set = 1'b1; nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign start_w  = (state == S_IDLE) && start_i;
  assign accept_w = (state == S_FETCH) && byte_valid_i;
  assign rise_w   = sh_step && sh_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rem       <= '0;
      polls     <= '0;
      ok_o      <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      state <= nxt;
      if (start_w)       rem <= count_i;
      else if (accept_w) rem <= rem - 1'b1;
      polls <= (state == S_POLL) ? polls + 1'b1 : '0;
      ok_o  <= ok_set;
      if (start_w)     timeout_o <= 1'b0;
      else if (to_set) timeout_o <= 1'b1;
    end
  end

  assign busy_o   = (state != S_IDLE);
  assign prog_n_o = (state != S_PROG);
  assign cclk_o   = !((state == S_SHIFT) && sh_low);
  assign din_o    = (state == S_SHIFT) ? sh_bit : 1'b1;

endmodule

// File: rtl/ssc_loader_chk.sv
module ssc_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic prog_n_o,
  input logic cclk_o,
  input logic din_o,
  input logic byte_ready_o,
  input logic busy_o,
  input logic ok_o,
  input logic timeout_o,
  input logic accept_w,
  input logic rise_w
);

  AST_PROG_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (cclk_o && din_o && busy_o)); // R1

  AST_DIN_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(din_o)); // R3

  AST_ACCEPT_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !cclk_o); // R3

  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> cclk_o); // R3

  AST_READY_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (cclk_o && busy_o && prog_n_o)); // R5

  AST_OK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |=> !ok_o); // R7

  AST_OK_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (!busy_o && !timeout_o)); // R7

  AST_TIMEOUT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> ($past(busy_o) && !busy_o)); // R8

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (prog_n_o && cclk_o && din_o && !byte_ready_o)); // R9

  AST_NO_REPROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && prog_n_o && start_i) |=> prog_n_o); // R10

endmodule

bind ssc_loader ssc_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_n_o(prog_n_o),
  .cclk_o(cclk_o), .din_o(din_o), .byte_ready_o(byte_ready_o), .busy_o(busy_o),
  .ok_o(ok_o), .timeout_o(timeout_o), .accept_w(accept_w), .rise_w(rise_w)
);

// File: tb/sim_ssc_loader.sv
module sim_ssc_loader;

  localparam int CLK_PERIOD = 10;
  localparam int RST_HOLD   = 6;
  localparam int REL_WAIT   = 3;
  localparam int HALF_PER   = 2;
  localparam int POLL_LIMIT = 1000;
  localparam int CNT_W      = 24;

  // {count, first byte, step, done delay (255 = never), restart mid-run}
  localparam int NVEC = 6;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd1, 8'hA5, 8'h00, 8'd0,   8'd0},
    {8'd3, 8'h80, 8'h01, 8'd5,   8'd0},
    {8'd4, 8'h01, 8'h3F, 8'd30,  8'd1},
    {8'd2, 8'hFF, 8'h01, 8'd0,   8'd0},
    {8'd5, 8'h3C, 8'h11, 8'd1,   8'd0},
    {8'd2, 8'h00, 8'h55, 8'd255, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic [7:0] byte_i = '0;
  logic byte_valid_i = 1'b0;
  logic done_i = 1'b0;
  logic byte_ready_o, prog_n_o, cclk_o, din_o, busy_o, ok_o, timeout_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Per-run observations
  int rx_bytes, byte_err, run_err, rdy_err, prog_low, rel_cnt, post_rise, ok_cnt, rises_tot, busy_cnt;

  ssc_loader #(
    .RST_HOLD(RST_HOLD), .REL_WAIT(REL_WAIT), .HALF_PER(HALF_PER),
    .POLL_LIMIT(POLL_LIMIT), .CNT_W(CNT_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i), .byte_i(byte_i),
    .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o), .done_i(done_i),
    .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o), .busy_o(busy_o),
    .ok_o(ok_o), .timeout_o(timeout_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nth_byte(input logic [7:0] b0, input logic [7:0] stp, input int k);
    return 8'(b0 + 8'(k) * stp);
  endfunction

  // Runs one job; all stimulus and observation at falling edges.
  task automatic run_job(input int n, input logic [7:0] b0, input logic [7:0] stp,
                         input int dly, input bit restart);
    int cyc, fed, rises, low_run, dwait;
    logic [7:0] rx;
    bit prev_cclk, prev_rdy, prev_val, acc_any, seen_low, rel_done;
    rx_bytes = 0; byte_err = 0; run_err = 0; rdy_err = 0; prog_low = 0;
    rel_cnt = 0; post_rise = 0; ok_cnt = 0; rises_tot = 0; busy_cnt = 0;
    fed = 0; rises = 0; low_run = 0; rx = '0; dwait = dly;
    acc_any = 1'b0; seen_low = 1'b0; rel_done = 1'b0;
    prev_cclk = 1'b1; prev_rdy = 1'b0; prev_val = 1'b0;
    @(negedge clk);
    count_i = CNT_W'(n);
    byte_i = nth_byte(b0, stp, 0);
    byte_valid_i = (n > 0);
    start_i = 1'b1;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      start_i = (restart && (cyc == 20));
      if (busy_o) busy_cnt++;
      if (prev_rdy && prev_val) begin
        acc_any = 1'b1; rises = 0; fed++;
        byte_i = nth_byte(b0, stp, fed);
        byte_valid_i = (fed < n);
      end
      if (cclk_o && !prev_cclk) begin
        rises++; rises_tot++;
        rx = {rx[6:0], din_o};
        post_rise = 0;
        if (low_run != HALF_PER) run_err++;
        if (rises == 8) begin
          if (rx != nth_byte(b0, stp, rx_bytes)) byte_err++;
          rx_bytes++;
        end
      end
      low_run = cclk_o ? 0 : low_run + 1;
      if (busy_o) post_rise++;
      if (!prog_n_o) prog_low++;
      if (!cclk_o) seen_low = 1'b1;
      if (prog_n_o && busy_o && !seen_low && prog_low > 0) rel_cnt++;
      if (byte_ready_o && acc_any && rises != 8) rdy_err++;
      if (ok_o) ok_cnt++;
      if (rx_bytes == n && dly != 255) begin
        if (dwait == 0) done_i = 1'b1; else dwait--;
      end
      prev_cclk = cclk_o; prev_rdy = byte_ready_o; prev_val = byte_valid_i;
      if (!busy_o) break;
    end
    byte_valid_i = 1'b0;
    rel_done = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(prog_n_o && cclk_o && din_o, "R9 lines high in reset", {prog_n_o, cclk_o, din_o}, 7);
    chk(!busy_o && !byte_ready_o && !ok_o && !timeout_o, "R9 flags low in reset",
        {busy_o, byte_ready_o, ok_o, timeout_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prog_n_o && cclk_o && din_o && !busy_o, "R9 idle after reset",
        {prog_n_o, cclk_o, din_o, busy_o}, 14);

    for (int v = 0; v < NVEC; v++) begin
      int n, dly;
      bit rs;
      n   = int'(VEC[v][39:32]);
      dly = int'(VEC[v][15:8]);
      rs  = VEC[v][0];
      done_i = 1'b0;
      run_job(n, VEC[v][31:24], VEC[v][23:16], dly, rs);
      chk(prog_low == RST_HOLD, "R1 program low length", prog_low, RST_HOLD);
      chk(rel_cnt == REL_WAIT + 1, "R2 release to first low clock", rel_cnt, REL_WAIT + 1);
      chk(run_err == 0, "R3 low phase length", run_err, 0);
      chk(rx_bytes == n && byte_err == 0, "R4 bytes received in order",
          rx_bytes * 100 + byte_err, n * 100);
      chk(rises_tot == 8 * n, "R4 rising edges per run", rises_tot, 8 * n);
      chk(rdy_err == 0, "R5 ready only after eighth edge", rdy_err, 0);
      if (dly != 255) begin
        chk(ok_cnt == 1 && !timeout_o, "R7 success pulse", ok_cnt, 1);
      end else begin
        chk(timeout_o && ok_cnt == 0, "R8 timeout flag", timeout_o, 1);
        chk(post_rise == HALF_PER + POLL_LIMIT, "R8 poll window length", post_rise,
            HALF_PER + POLL_LIMIT);
      end
      if (rs) chk(prog_low == RST_HOLD && byte_err == 0, "R10 restart ignored", prog_low, RST_HOLD);
      chk(prog_n_o && cclk_o && din_o && !byte_ready_o, "R9 lines high after run",
          {prog_n_o, cclk_o, din_o, byte_ready_o}, 14);
    end

    // R8: flag held after timeout, then cleared by a new start
    repeat (10) @(negedge clk);
    chk(timeout_o == 1'b1, "R8 timeout held", timeout_o, 1);
    @(negedge clk);
    done_i = 1'b1;
    count_i = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(timeout_o == 1'b0, "R8 timeout cleared by start", timeout_o, 0);
    begin
      int bc, rz, oc;
      bc = 1; rz = 0; oc = 0;
      while (busy_o) begin
        @(negedge clk);
        if (busy_o) bc++;
        if (!cclk_o) rz++;
        if (ok_o) oc++;
      end
      // R6: zero-byte run goes straight to polling
      chk(bc == RST_HOLD + REL_WAIT + 1, "R6 zero-count busy length", bc, RST_HOLD + REL_WAIT + 1);
      chk(rz == 0, "R6 no clock pulses", rz, 0);
      chk(oc == 1, "R7 success with done already high", oc, 1);
    end

    // R7: late done within the window, single byte
    done_i = 1'b0;
    run_job(1, 8'h5A, 8'h00, 200, 1'b0);
    chk(ok_cnt == 1 && !timeout_o, "R7 late done accepted", ok_cnt, 1);
    chk(rx_bytes == 1 && byte_err == 0, "R4 single byte 5A", byte_err, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule